// File: doc/BRIEF.md
# Indexed Register Port with Clock-Measurement Counter

This block is a byte-wide register file that a host reaches through two small address windows, one for the primary channel and one for the secondary channel. Each window has an index port and a data port. The host first writes an 8-bit index to the index port of a window. Reads and writes to that window's data port then act on the register the index selects. The two windows keep separate indices.

Behind the windows are several registers. A control byte holds a run bit that gates a 30-bit down-counter, which software uses to measure an input clock. The counter's value is read back as four bytes spread over the two windows. Each channel has a read-only cable-status byte and a bank of per-drive timing bytes. Two PLL control bytes in the secondary window drive output pins. Nothing holds the count while the host reads its four bytes, so software must re-read when the upper bytes may have moved.

Host accesses are synchronous to `clk`. A data read returns its byte one cycle after the read strobe. The counter steps on `tick`, a one-cycle pulse for each input-clock event.

Top module: `idx_port_counter`

## Requirements
- R1: After reset the following are all zero and the counter is stopped: both indices, the control byte, the PLL bytes, every timing byte, the counter and `rdata`.
- R2: Bit 3 of `addr` selects the window (0 = primary, 1 = secondary) and bits 2:0 give the offset. A write at offset 1 loads that window's index, and a read at offset 1 returns it. Accesses at offset 3 act on the register the window's own index selects. All other offsets read 0x00 and ignore writes.
- R3: Primary index 0x01 is a read/write control byte. While its bit 6 is 1, the counter drops by one on every cycle with `tick` high, and `counter_run` is 1. While bit 6 is 0, the counter holds its value.
- R4: The counter is 30 bits wide and wraps from 0 to 0x3FFFFFFF.
- R5: The count bytes are laid out as follows. Primary 0x20 reads count[7:0]. Primary 0x21 reads {0, count[14:8]}. Secondary 0x20 reads count[22:15]. Secondary 0x21 reads {0, count[29:23]}.
- R6: The count bytes are read-only, and writes to them are ignored. Each read returns the live count at the read cycle, with no latching across bytes.
- R7: Index 0x0B of each window reads bit 2 = `cable40` of that channel (1 = 40-wire cable) and all other bits 0. Writes to it are ignored.
- R8: Indices 0x0C to 0x1B of each window are read/write timing bytes, with drive 1's bytes 8 above drive 0's. The byte at index i of channel c appears on `timing[(c*16 + i - 0x0C)*8 +: 8]`.
- R9: Secondary indices 0x02 and 0x03 are read/write PLL bytes, driven on `pll_ctl[7:0]` and `pll_ctl[15:8]` respectively.
- R10: A data access to an index with no register behind it reads 0x00 and changes no state. This includes primary 0x02/0x03, secondary 0x01 and indices above 0x21.
- R11: `rdata` takes the selected value on the clock edge where `rd_en` is high and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Input-clock event pulse for the counter |
| addr | input | 4 | Bit 3 selects the window; bits 2:0 give the offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cable40 | input | 2 | Per-channel cable sense, 1 = 40-wire cable |
| counter_run | output | 1 | Control bit 6 |
| pll_ctl | output | 16 | PLL control bytes {0x03, 0x02} |
| timing | output | 256 | Timing bytes of both channels |

## Verification
Counter values are tried at three points: one tick from zero, which shows the wrap and every byte position, a few further ticks, which move only the low byte, and a stopped run, which shows the freeze. Reads with `tick` held high show that each byte is sampled live, one step apart. Timing writes at the first byte, the drive-1 offset and the last byte of the far window show that the index offset and channel map onto the right output bytes. Writes to cable, count and unmapped indices, with the neighbouring state read back afterwards, show that nothing leaks into real registers.

// File: rtl/idx_port_counter.sv
module idx_port_counter #(
  parameter int TMG_BASE = 12,
  parameter int TMG_NUM  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [3:0]             addr,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [1:0]             cable40,
  output logic                   counter_run,
  output logic [15:0]            pll_ctl,
  output logic [2*TMG_NUM*8-1:0] timing
);
  localparam int TW    = $clog2(TMG_NUM);
  localparam int CNT_W = 30;

  logic [7:0]       idx [2];
  logic [7:0]       ctrl;
  logic [7:0]       pll [2];
  logic [7:0]       tmg [2][TMG_NUM];
  logic [CNT_W-1:0] count;
  logic [7:0]       rd_val;

  wire       ch     = addr[3];
  wire [2:0] off    = addr[2:0];
  wire       idx_we = wr_en && (off == 3'd1);
  wire       dat_we = wr_en && (off == 3'd3);
  wire [7:0] sel    = idx[ch];
  wire       tmg_hit = (int'(sel) >= TMG_BASE) && (int'(sel) < TMG_BASE + TMG_NUM);
  wire [TW-1:0] tmg_ofs = TW'(int'(sel) - TMG_BASE);

  assign counter_run = ctrl[6];
  assign pll_ctl     = {pll[1], pll[0]};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    for (genvar i = 0; i < TMG_NUM; i++) begin : g_b
      assign timing[(c*TMG_NUM+i)*8 +: 8] = tmg[c][i];
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (off == 3'd1) rd_val = sel;
    else if (off == 3'd3) begin
      if (tmg_hit) rd_val = tmg[ch][tmg_ofs];
      else begin
        case ({ch, sel})
          9'h001:          rd_val = ctrl;
          9'h00B, 9'h10B:  rd_val = {5'b0, cable40[ch], 2'b0};
          9'h020:          rd_val = count[7:0];
          9'h021:          rd_val = {1'b0, count[14:8]};
          9'h120:          rd_val = count[22:15];
          9'h121:          rd_val = {1'b0, count[29:23]};
          9'h102:          rd_val = pll[0];
          9'h103:          rd_val = pll[1];
          default:         rd_val = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx[0] <= '0;
      idx[1] <= '0;
      ctrl   <= '0;
      pll[0] <= '0;
      pll[1] <= '0;
      count  <= '0;
      rdata  <= '0;
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < TMG_NUM; i++)
          tmg[c][i] <= '0;
    end else begin
      if (idx_we) idx[ch] <= wdata;
      if (dat_we) begin
        if (tmg_hit)                     tmg[ch][tmg_ofs] <= wdata;
        else if (!ch && sel == 8'h01)    ctrl   <= wdata;
        else if (ch && sel == 8'h02)     pll[0] <= wdata;
        else if (ch && sel == 8'h03)     pll[1] <= wdata;
      end
      if (rd_en) rdata <= rd_val;
      if (ctrl[6] && tick) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/idx_port_counter_chk.sv
module idx_port_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [7:0]  idx_p,
  input logic [1:0]  cable40,
  input logic        run,
  input logic [29:0] count
);
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count != 30'd0) |=> count == $past(count) - 30'd1); // R3
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count == 30'd0) |=> count == 30'h3FFFFFFF); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R11
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h1) |=> idx_p == $past(wdata)); // R2
  AST_CABLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'h3 && idx_p == 8'h0B) |=> rdata == {5'b0, $past(cable40[0]), 2'b0}); // R7
endmodule

bind idx_port_counter idx_port_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .idx_p(idx[0]),
  .cable40(cable40), .run(ctrl[6]), .count(count)
);

// File: tb/idx_port_counter_test.sv
module idx_port_counter_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         tick = 0;
  logic [3:0]   addr = '0;
  logic         wr_en = 0;
  logic         rd_en = 0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [1:0]   cable40 = 2'b01;
  logic         counter_run;
  logic [15:0]  pll_ctl;
  logic [255:0] timing;

  int checks = 0;
  int errors = 0;
  logic [7:0]  got;
  logic [29:0] exp_cnt;

  always #5 clk = ~clk;

  idx_port_counter uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .cable40(cable40),
    .counter_run(counter_run), .pll_ctl(pll_ctl), .timing(timing)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    got = rdata;
  endtask

  task automatic regw(input logic ch, input logic [7:0] i, input logic [7:0] d);
    wr({ch, 3'd1}, i);
    wr({ch, 3'd3}, d);
  endtask

  task automatic regr(input logic ch, input logic [7:0] i);
    wr({ch, 3'd1}, i);
    rd({ch, 3'd3});
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1;
      @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic check_count(input string req);
    regr(0, 8'h20); chk(got, exp_cnt[7:0], req);
    regr(0, 8'h21); chk(got, {1'b0, exp_cnt[14:8]}, req);
    regr(1, 8'h20); chk(got, exp_cnt[22:15], req);
    regr(1, 8'h21); chk(got, {1'b0, exp_cnt[29:23]}, req);
  endtask

  task automatic t_reset;
    chk(rdata, 0, "R1 rdata");
    chk(counter_run, 0, "R1 run");
    chk(pll_ctl, 0, "R1 pll");
    chk(timing[31:0] | timing[255:224], 0, "R1 timing");
    rd(4'h1); chk(got, 0, "R1 pri index");
    rd(4'h9); chk(got, 0, "R1 sec index");
    exp_cnt = '0;
    check_count("R1 count");
  endtask

  task automatic t_index;
    wr(4'h1, 8'h0C);
    wr(4'h9, 8'h14);
    rd(4'h1); chk(got, 8'h0C, "R2 pri index");
    rd(4'h9); chk(got, 8'h14, "R2 sec index");
    rd(4'h2); chk(got, 8'h00, "R2 other offset");
    wr(4'h5, 8'hEE);
    rd(4'h1); chk(got, 8'h0C, "R2 index after stray write");
  endtask

  task automatic t_timing;
    regw(0, 8'h0C, 8'hA5);
    regw(0, 8'h14, 8'h3C);
    regw(1, 8'h1B, 8'h77);
    chk(timing[7:0], 8'hA5, "R8 pri drive0 first");
    chk(timing[71:64], 8'h3C, "R8 pri drive1 first");
    chk(timing[255:248], 8'h77, "R8 sec last");
    chk(timing[135:128], 8'h00, "R8 sec first untouched");
    regr(0, 8'h14); chk(got, 8'h3C, "R8 readback");
    regr(1, 8'h0C); chk(got, 8'h00, "R8 channel separation");
  endtask

  task automatic t_pll;
    regw(1, 8'h02, 8'h1E);
    regw(1, 8'h03, 8'h0D);
    chk(pll_ctl, 16'h0D1E, "R9 pll pins");
    regr(1, 8'h03); chk(got, 8'h0D, "R9 readback");
    regr(0, 8'h02); chk(got, 8'h00, "R10 pri 0x02 empty");
  endtask

  task automatic t_cable;
    cable40 = 2'b01;
    regr(0, 8'h0B); chk(got, 8'h04, "R7 pri 40-wire");
    regr(1, 8'h0B); chk(got, 8'h00, "R7 sec 80-wire");
    regw(0, 8'h0B, 8'hFF);
    regr(0, 8'h0B); chk(got, 8'h04, "R7 write ignored");
    cable40 = 2'b10;
    regr(1, 8'h0B); chk(got, 8'h04, "R7 sec follows pin");
  endtask

  task automatic t_counter;
    regw(0, 8'h01, 8'h40);
    chk(counter_run, 1, "R3 run out");
    regr(0, 8'h01); chk(got, 8'h40, "R3 ctrl readback");
    pulse_ticks(1);
    exp_cnt = 30'h3FFFFFFF;
    check_count("R4 wrap");
    pulse_ticks(5);
    exp_cnt = exp_cnt - 30'd5;
    check_count("R5 after five");
    regw(0, 8'h20, 8'h00);
    regw(1, 8'h21, 8'h00);
    check_count("R6 write ignored");
    regw(0, 8'h01, 8'h00);
    chk(counter_run, 0, "R3 stopped");
    pulse_ticks(4);
    check_count("R3 frozen");
  endtask

  task automatic t_live;
    logic [7:0] a;
    regw(0, 8'h01, 8'h40);
    wr(4'h1, 8'h20);
    tick = 1;
    rd(4'h3); a = got;
    rd(4'h3);
    tick = 0;
    chk(8'(a - got), 8'd1, "R6 live count");
    regw(0, 8'h01, 8'h00);
  endtask

  task automatic t_unmapped;
    regw(0, 8'h40, 8'h55);
    regr(0, 8'h40); chk(got, 8'h00, "R10 high index");
    regw(1, 8'h01, 8'h40);
    regr(1, 8'h01); chk(got, 8'h00, "R10 sec 0x01");
    chk(counter_run, 0, "R10 ctrl untouched");
    regw(1, 8'hFF, 8'h99);
    chk(pll_ctl, 16'h0D1E, "R10 pll untouched");
    chk(timing[7:0], 8'hA5, "R10 timing untouched");
  endtask

  task automatic t_hold;
    regr(0, 8'h0C);
    chk(got, 8'hA5, "R11 read");
    wr(4'h1, 8'h0B);
    @(negedge clk);
    chk(rdata, 8'hA5, "R11 hold");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_index();
        t_timing();
        t_pll();
        t_cable();
        t_counter();
        t_live();
        t_unmapped();
        t_hold();
      end
      begin
        repeat (20000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule